// File: doc/BRIEF.md
# Fixed-Period Winding Current Chopper

This block keeps the current in one motor winding near a reference by chopping the winding switch at a fixed rate. The system clock is divided by a fixed ratio to make the chopping period. Every phase of a drive shares the same period boundaries, so all windings chop in step with each other. At each boundary the drive latch is set and the switch gate turns on. The gate then stays on until the digitised current comparator reports that the sensed current has reached its reference. After that the gate stays off until the next boundary. There is no separate off-time timer.

The comparator input is asynchronous, so it passes through a short synchroniser chain. For a fixed number of clocks after every set, the synchronised comparator is ignored. This blanking window hides the current spike at turn-on and also the stale synchroniser contents left over from the previous period. The gate can be on only while both the enable and the phase-drive request for the winding are high. Dropping either one cuts the gate at once. The switch then waits for a fresh period boundary before it turns on again.

Top module: `chop_pwm_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the period divider, the synchroniser, the blanking counter and the drive latch, so `gate_on` is 0 while reset is held. After release, the first period boundary is the DIV_RATIO-th rising clock edge, and `gate_on` stays 0 until that edge.
- R2: Period boundaries repeat every DIV_RATIO clocks (default 18). The divider runs freely and does not depend on enable, request or comparator.
- R3: If `enable` and `phase_req` are both 1 at a boundary edge, `gate_on` is 1 in the cycle that follows. This is the only way `gate_on` can go from 0 to 1.
- R4: `cmp_trip` passes through SYNC_STAGES flops (default 2). If `cmp_trip` is raised in period position t, the synchronised value is seen in position t+SYNC_STAGES. If that position is outside blanking, `gate_on` is 0 from the following position until the next boundary. Each period therefore has at most one on-interval.
- R5: During the BLANK_CYC clocks after each boundary (default 4), the synchronised comparator has no effect. With `cmp_trip` held high, `gate_on` is on for positions 0 to BLANK_CYC and off from position BLANK_CYC+1.
- R6: If a trip would be accepted at the same edge as a boundary, the set wins. The new period starts with `gate_on` = 1.
- R7: `enable` = 0 forces `gate_on` to 0 in the same cycle and clears the latch. If `enable` returns to 1 mid-period, `gate_on` stays 0 until the next boundary.
- R8: `phase_req` = 0 forces `gate_on` to 0 in the same cycle and clears the latch. If `phase_req` returns to 1 mid-period, `gate_on` stays 0 until the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that is divided into the chopping period |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Output enable; 0 cuts the drive and clears the latch |
| phase_req | input | 1 | Phase-drive request for this winding from the sequencer |
| cmp_trip | input | 1 | Asynchronous comparator result; 1 means the sensed current has reached the reference |
| gate_on | output | 1 | Switch gate drive; 1 turns the winding switch on |

## Verification
The hardest case to reach is a synchronised trip that lands on the last position of a period, so that it meets the next set on the same edge. The stimulus reaches it by raising the comparator exactly SYNC_STAGES+1 positions before the boundary. The next period is then checked to start with the gate on. The bench tracks the period position from the release of reset. For each vector, it places a comparator rise at a chosen position and derives the off position from the synchroniser latency and the blanking length. It also drops enable and request in the middle of a period and checks that turn-on waits for the following boundary.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Action applied to the drive latch at the next clock edge
  typedef enum logic [1:0] {
    CMD_HOLD,
    CMD_SET,
    CMD_TRIP,
    CMD_DROP
  } latch_cmd_e;

  // Bits needed to hold values 0 .. n-1
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Priority: missing permission, then period set, then accepted trip
  function automatic latch_cmd_e pick_cmd(input logic allow,
                                          input logic set_now,
                                          input logic trip_ok);
    if (!allow)       return CMD_DROP;
    else if (set_now) return CMD_SET;
    else if (trip_ok) return CMD_TRIP;
    else              return CMD_HOLD;
  endfunction

  // Next latch state for a given command
  function automatic logic apply_cmd(input latch_cmd_e cmd, input logic cur);
    case (cmd)
      CMD_SET:  return 1'b1;
      CMD_TRIP: return 1'b0;
      CMD_DROP: return 1'b0;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/chop_period_gen.sv
module chop_period_gen #(
  parameter int unsigned DIV_RATIO = 18
) (
  input  logic clk,
  input  logic rst_n,
  output logic period_set
);
  localparam int unsigned CW = chop_pkg::cnt_bits(DIV_RATIO);
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] pos_q;

  // Free-running position counter inside the chopping period
  always_ff @(posedge clk) begin
    if (!rst_n)             pos_q <= '0;
    else if (pos_q == LAST) pos_q <= '0;
    else                    pos_q <= pos_q + CW'(1);
  end

  // High in the last cycle of the period; the following edge is the boundary
  assign period_set = (pos_q == LAST);

endmodule

// File: rtl/chop_cmp_filter.sv
module chop_cmp_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BLANK_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw,
  input  logic period_set,
  output logic trip_sync,
  output logic blank_active
);
  localparam int unsigned BW = chop_pkg::cnt_bits(BLANK_CYC + 1);

  // Synchroniser chain for the asynchronous comparator input
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign trip_sync = cmp_raw;
    end else if (SYNC_STAGES == 1) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= cmp_raw;
      end
      assign trip_sync = sync_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_raw};
      end
      assign trip_sync = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // Blanking down-counter, reloaded on every period boundary
  logic [BW-1:0] blank_q;
  always_ff @(posedge clk) begin
    if (!rst_n)              blank_q <= '0;
    else if (period_set)     blank_q <= BW'(BLANK_CYC);
    else if (blank_q != '0)  blank_q <= blank_q - BW'(1);
  end

  assign blank_active = (blank_q != '0);

endmodule

// File: rtl/chop_drive_latch.sv
module chop_drive_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic period_set,
  input  logic trip_sync,
  input  logic blank_active,
  output logic latch_q,
  output logic gate_on
);
  import chop_pkg::*;

  logic       trip_ok;
  latch_cmd_e cmd;

  assign trip_ok = trip_sync & ~blank_active;
  assign cmd     = pick_cmd(allow, period_set, trip_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= apply_cmd(cmd, latch_q);
  end

  // Permission gates the output without waiting for a clock edge
  assign gate_on = latch_q & allow;

endmodule

// File: rtl/chop_pwm_ctrl.sv
module chop_pwm_ctrl #(
  parameter int unsigned DIV_RATIO   = 18,
  parameter int unsigned BLANK_CYC   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic phase_req,
  input  logic cmp_trip,
  output logic gate_on
);
  // Internal events, named for the bound checker
  logic period_set;
  logic trip_sync;
  logic blank_active;
  logic latch_q;
  logic allow;

  assign allow = enable & phase_req;

  chop_period_gen #(.DIV_RATIO(DIV_RATIO)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_set (period_set)
  );

  chop_cmp_filter #(.SYNC_STAGES(SYNC_STAGES), .BLANK_CYC(BLANK_CYC)) u_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_raw      (cmp_trip),
    .period_set   (period_set),
    .trip_sync    (trip_sync),
    .blank_active (blank_active)
  );

  chop_drive_latch u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .allow        (allow),
    .period_set   (period_set),
    .trip_sync    (trip_sync),
    .blank_active (blank_active),
    .latch_q      (latch_q),
    .gate_on      (gate_on)
  );

endmodule

// File: rtl/chop_pwm_ctrl_chk.sv
module chop_pwm_ctrl_chk #(
  parameter int unsigned DIV_RATIO = 18
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic phase_req,
  input logic gate_on,
  input logic period_set,
  input logic blank_active,
  input logic trip_sync,
  input logic latch_q
);
  // Independent count of clocks since the last boundary
  int unsigned gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          gap_q <= 0;
    else if (period_set) gap_q <= 0;
    else                 gap_q <= gap_q + 1;
  end

  p_period_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_set |-> (gap_q == DIV_RATIO - 1));

  p_rise_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(period_set));

  p_off_until_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_on && !period_set) |=> !gate_on);

  p_trip_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_sync && !blank_active && !period_set) |=> !latch_q);

  p_blank_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && blank_active && enable && phase_req) |=> latch_q);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_set && enable && phase_req) |=> latch_q);

  // Covers R7 and R8: losing permission clears the latch
  p_drop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || !phase_req) |=> !latch_q);

endmodule

bind chop_pwm_ctrl chop_pwm_ctrl_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .phase_req    (phase_req),
  .gate_on      (gate_on),
  .period_set   (period_set),
  .blank_active (blank_active),
  .trip_sync    (trip_sync),
  .latch_q      (latch_q)
);

// File: tb/chop_pwm_ctrl_test.sv
`timescale 1ns/1ps
module chop_pwm_ctrl_test;
  localparam int DIV   = 18;
  localparam int BLANK = 4;
  localparam int SYNC  = 2;
  localparam int NO_TRIP = 31;
  localparam int NVEC = 12;

  // {enable, phase_req, trip position (31 = none)}
  localparam logic [6:0] VECS [NVEC] = '{
    {1'b1, 1'b1, 5'd31},
    {1'b1, 1'b1, 5'd2},
    {1'b1, 1'b1, 5'd0},
    {1'b1, 1'b1, 5'd8},
    {1'b1, 1'b1, 5'd14},
    {1'b1, 1'b1, 5'd15},
    {1'b1, 1'b1, 5'd31},
    {1'b0, 1'b1, 5'd31},
    {1'b1, 1'b0, 5'd3},
    {1'b0, 1'b0, 5'd5},
    {1'b1, 1'b1, 5'd10},
    {1'b1, 1'b1, 5'd31}
  };

  logic clk = 1'b0;
  logic rst_n, enable, phase_req, cmp_trip;
  logic gate_on;
  int   applied = 0;
  int   miscmp = 0;
  int   pos = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  chop_pwm_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .phase_req (phase_req),
    .cmp_trip  (cmp_trip),
    .gate_on   (gate_on)
  );

  // Position where the gate should first read low for a trip raised at t
  function automatic int off_position(input int t);
    int seen;
    seen = t + SYNC;
    if (seen < BLANK) seen = BLANK;
    return seen + 1;
  endfunction

  function automatic logic expect_gate(input logic en, input logic rq,
                                       input int t, input int j);
    if (!(en && rq))  return 1'b0;
    if (t == NO_TRIP) return 1'b1;
    return (j < off_position(t));
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s: pos=%0d gate_on=%b expected %b", tag, pos, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    pos = (pos + 1) % DIV;
  endtask

  task automatic run_to(input int target);
    while (pos != target) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: run still busy, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; phase_req = 1'b0; cmp_trip = 1'b0;
    repeat (3) step();
    #1 check("R1 reset holds output low", gate_on, 1'b0);
    rst_n = 1'b1;
    pos = 0;
    run_to(DIV - 1);

    // Vector walk: one period per entry, aligned so drive changes land before a boundary
    for (int v = 0; v < NVEC; v++) begin
      logic en_v, rq_v;
      int   t_v;
      string tag;
      en_v = VECS[v][6];
      rq_v = VECS[v][5];
      t_v  = int'(VECS[v][4:0]);
      if (!(en_v && rq_v))            tag = "R7/R8 permission low";
      else if (t_v == NO_TRIP)        tag = "R3 untripped period";
      else if (off_position(t_v) >= DIV) tag = "R6 late trip vs set";
      else if (t_v + SYNC < BLANK)    tag = "R5 blanked trip";
      else                            tag = "R4 trip cutoff";
      enable = en_v; phase_req = rq_v; cmp_trip = 1'b0;
      for (int j = 0; j < DIV; j++) begin
        step();
        if (t_v != NO_TRIP && j >= t_v) cmp_trip = 1'b1;
        #1 check(tag, gate_on, expect_gate(en_v, rq_v, t_v, j));
      end
    end
    cmp_trip = 1'b0;

    // R7: enable dropped mid-period
    enable = 1'b1; phase_req = 1'b1;
    run_to(6);
    enable = 1'b0;
    #1 check("R7 enable low cuts gate at once", gate_on, 1'b0);
    step();
    enable = 1'b1;
    #1 check("R7 enable restored mid-period stays off", gate_on, 1'b0);
    run_to(DIV - 1);
    #1 check("R7 off until boundary", gate_on, 1'b0);
    step();
    #1 check("R3 turn-on at boundary after enable", gate_on, 1'b1);

    // R8: request dropped mid-period
    run_to(9);
    phase_req = 1'b0;
    #1 check("R8 request low cuts gate at once", gate_on, 1'b0);
    step();
    phase_req = 1'b1;
    #1 check("R8 request restored mid-period stays off", gate_on, 1'b0);
    run_to(DIV - 1);
    #1 check("R8 off until boundary", gate_on, 1'b0);
    step();
    #1 check("R3 turn-on at boundary after request", gate_on, 1'b1);

    // R1: reset mid-run, then the first boundary after release
    run_to(4);
    rst_n = 1'b0;
    step();
    #1 check("R1 synchronous reset clears output", gate_on, 1'b0);
    step();
    rst_n = 1'b1;
    pos = 0;
    for (int k = 1; k < DIV; k++) begin
      step();
      #1 check("R1 no turn-on before first boundary", gate_on, 1'b0);
    end
    step();
    #1 check("R2 first boundary after DIV edges", gate_on, 1'b1);

    // R2/R5: trip held high over a full period, gate returns on next boundary
    cmp_trip = 1'b1;
    run_to(BLANK);
    #1 check("R5 held trip masked through blanking", gate_on, 1'b1);
    step();
    #1 check("R5 held trip acts right after blanking", gate_on, 1'b0);
    run_to(DIV - 1);
    cmp_trip = 1'b0;
    #1 check("R4 stays off to end of period", gate_on, 1'b0);
    step();
    #1 check("R2 next boundary turns gate on", gate_on, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

endmodule